// File: doc/BRIEF.md
# Device-to-Host Virtual Wire Group

This block holds one group of four outgoing virtual wires that local firmware drives toward the host over a shared link. Firmware sets an 8-bit host index that names the group, the state of each wire, and a reset configuration. The reset configuration picks one of four reset domains and gives a 4-bit pattern of wire states to load when that domain resets. Each wire has a change flag. A firmware write that gives a wire a new value sets the flag for that wire. Any flag that is set raises a transmit request toward the link.

When the link accepts the request, the block presents the index and all four wire states as one message. This is true even if only some of the wires changed. In the same cycle the block clears the flags that were pending at that moment. A change that firmware makes in the cycle of an accept stays pending, so the new value goes out in the next message.

Firmware reaches the block through a byte-wide register port with eight byte slots. Reads are combinational. Each wire sits in its own byte slot, so firmware can update one wire with a single byte write and never needs a read-modify-write.

Top module: `d2h_vwire_group`

## Requirements
- R1: After the hardware reset the index, the reset configuration, all wire states and all change flags are zero, and tx_req is low.
- R2: Byte map. Byte 0 is the index and is read/write. Byte 1 is the reset configuration: bits [1:0] select the domain (0 link, 1 system, 2 I/O, 3 platform), bits [7:4] hold the reset pattern (bit 4+n is for wire n), and bits [3:2] read 0. Byte 2 returns the change flags in bits [3:0] (bit n for wire n), and writes to it are ignored. Byte 3 reads 0. Bytes 4 to 7 hold wires 0 to 3: only bit 0 is stored, and the other bits read 0.
- R3: A write that gives a wire a value different from its current one updates the wire and sets its change flag from the next cycle.
- R4: A write that gives a wire the value it already holds leaves that wire's change flag unchanged.
- R5: tx_req is high whenever any change flag is set, and it stays high until an accept.
- R6: tx_index always shows the index and tx_wires shows all four wire states (bit n is wire n). A message therefore carries every wire, changed or not.
- R7: An accept is a cycle where tx_req and tx_grant are both high. It clears every flag that was set in that cycle. tx_grant while tx_req is low has no effect.
- R8: A wire change written in the same cycle as an accept leaves that wire's flag set afterwards, and tx_req stays high.
- R9: A pulse on rst_evt[n] in the domain selected by byte 1 loads the reset pattern into the wires and clears all flags. Pulses in other domains have no effect, and the index and reset configuration are kept.
- R10: A reset pulse in the selected domain takes priority over a wire write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 3 | Byte slot address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed slot (combinational) |
| rst_evt | input | 4 | One pulse per reset domain: link, system, I/O, platform |
| tx_req | output | 1 | At least one wire change is waiting to be sent |
| tx_grant | input | 1 | The link takes the message this cycle |
| tx_index | output | 8 | Host index of the message |
| tx_wires | output | 4 | States of all four wires in the message |

## Verification
Errors in the wire states or flags show up at the ports one clock after the write, accept or reset pulse that causes them. They appear as a wrong tx_req level, a wrong tx_wires pattern or a wrong flags byte. The bench sweeps every pair of old and new four-wire patterns, with the old pattern loaded through a reset pulse. After each sweep step it expects the flags to equal the XOR of the two patterns, tx_req to match whether they differ, and one accept to clear the flags. Directed cycles add the collisions between an accept or a reset pulse and a write in the same cycle, where a wrong priority leaves a stale flag one clock later.

// File: rtl/vw_pkg.sv
package vw_pkg;
  localparam int BYTE_W      = 8;
  localparam int SLOT_ADDR_W = 3;
  localparam int SLOT_INDEX  = 0;
  localparam int SLOT_RSTCFG = 1;
  localparam int SLOT_FLAGS  = 2;
  localparam int SLOT_WIRE0  = 4;
  localparam int MAP_LSB     = 4;

  typedef enum logic [1:0] {
    DOM_LINK     = 2'd0,
    DOM_SYSTEM   = 2'd1,
    DOM_IO       = 2'd2,
    DOM_PLATFORM = 2'd3
  } rst_dom_e;
endpackage

// File: rtl/vw_cfg_regs.sv
module vw_cfg_regs
  import vw_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int NUM_WIRES = 4,
  parameter int SRC_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   idx_wr,
  input  logic                   cfg_wr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [IDX_W-1:0]       index_q,
  output logic [SRC_W-1:0]       src_q,
  output logic [NUM_WIRES-1:0]   map_q
);
  logic [IDX_W-1:0]     index_d;
  logic [SRC_W-1:0]     src_d;
  logic [NUM_WIRES-1:0] map_d;

  always_comb begin
    index_d = index_q;
    src_d   = src_q;
    map_d   = map_q;
    if (idx_wr) index_d = wr_data[IDX_W-1:0];
    if (cfg_wr) begin
      src_d = wr_data[SRC_W-1:0];
      map_d = wr_data[MAP_LSB +: NUM_WIRES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      src_q   <= '0;
      map_q   <= '0;
    end else begin
      if (idx_wr) index_q <= index_d;
      if (cfg_wr) begin
        src_q <= src_d;
        map_q <= map_d;
      end
    end
  end

  // R2: index slot captures the written byte
  a_r2_index_capture: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> index_q == $past(wr_data[IDX_W-1:0]));
  // R9: configuration is only changed by its own slot write
  a_r9_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(src_q) && $stable(map_q)));
endmodule

// File: rtl/vw_wire_cell.sv
module vw_wire_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic rst_hit,
  input  logic rst_bit,
  input  logic sent,
  output logic state_q,
  output logic flag_q
);
  logic changed;
  logic state_d;
  logic flag_d;
  logic cell_en;

  always_comb begin
    changed = wr_hit && (wr_bit != state_q);
    cell_en = rst_hit || wr_hit || sent;
    if (rst_hit) begin
      state_d = rst_bit;
      flag_d  = 1'b0;
    end else begin
      state_d = wr_hit ? wr_bit : state_q;
      flag_d  = (flag_q && !sent) || changed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      flag_q  <= 1'b0;
    end else if (cell_en) begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  // R3: a new value marks the wire as changed
  a_r3_new_value_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (wr_bit != state_q) && !rst_hit) |=> (flag_q && state_q == $past(wr_bit)));
  // R4: rewriting the held value leaves a clear flag clear
  a_r4_same_value_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (wr_bit == state_q) && !flag_q && !rst_hit) |=> !flag_q);
  // R7: an accepted flag clears unless a fresh change arrives
  a_r7_sent_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && !wr_hit && !rst_hit) |=> !flag_q);
  // R8: change during accept stays pending
  a_r8_change_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && wr_hit && (wr_bit != state_q) && !rst_hit) |=> flag_q);
  // R9 / R10: selected reset loads the pattern and clears the flag
  a_r10_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (state_q == $past(rst_bit) && !flag_q));
endmodule

// File: rtl/vw_tx_gate.sv
module vw_tx_gate #(
  parameter int NUM_WIRES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRES-1:0] flags,
  input  logic                 tx_grant,
  input  logic                 rst_hit,
  output logic                 tx_req,
  output logic [NUM_WIRES-1:0] sent_mask
);
  logic accept;

  always_comb begin
    tx_req    = |flags;
    accept    = tx_req && tx_grant;
    sent_mask = accept ? flags : '0;
  end

  // R5: a pending request holds until accepted or reset
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_grant && !rst_hit) |=> tx_req);
  // R7: at most the pending flags are reported as sent
  a_r7_sent_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_mask & ~flags) == '0);
endmodule

// File: rtl/d2h_vwire_group.sv
module d2h_vwire_group
  import vw_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int NUM_WIRES   = 4,
  parameter int NUM_RST_SRC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [SLOT_ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0]      reg_wdata,
  output logic [BYTE_W-1:0]      reg_rdata,
  input  logic [NUM_RST_SRC-1:0] rst_evt,
  output logic                   tx_req,
  input  logic                   tx_grant,
  output logic [IDX_W-1:0]       tx_index,
  output logic [NUM_WIRES-1:0]   tx_wires
);
  localparam int SRC_W = $clog2(NUM_RST_SRC);

  logic                 idx_wr;
  logic                 cfg_wr;
  logic [IDX_W-1:0]     index_q;
  logic [SRC_W-1:0]     src_q;
  logic [NUM_WIRES-1:0] map_q;
  logic [NUM_WIRES-1:0] state_q;
  logic [NUM_WIRES-1:0] flag_q;
  logic [NUM_WIRES-1:0] sent_mask;
  logic [NUM_WIRES-1:0] wr_hit;
  logic                 rst_hit;

  always_comb begin
    idx_wr  = reg_wr && (reg_addr == SLOT_ADDR_W'(SLOT_INDEX));
    cfg_wr  = reg_wr && (reg_addr == SLOT_ADDR_W'(SLOT_RSTCFG));
    rst_hit = rst_evt[src_q];
  end

  vw_cfg_regs #(
    .IDX_W(IDX_W), .NUM_WIRES(NUM_WIRES), .SRC_W(SRC_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .cfg_wr(cfg_wr),
    .wr_data(reg_wdata), .index_q(index_q), .src_q(src_q), .map_q(map_q)
  );

  for (genvar gi = 0; gi < NUM_WIRES; gi++) begin : g_wire
    assign wr_hit[gi] = reg_wr && (reg_addr == SLOT_ADDR_W'(SLOT_WIRE0 + gi));
    vw_wire_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[gi]), .wr_bit(reg_wdata[0]),
      .rst_hit(rst_hit), .rst_bit(map_q[gi]),
      .sent(sent_mask[gi]),
      .state_q(state_q[gi]), .flag_q(flag_q[gi])
    );
  end

  vw_tx_gate #(.NUM_WIRES(NUM_WIRES)) u_tx (
    .clk(clk), .rst_n(rst_n), .flags(flag_q), .tx_grant(tx_grant),
    .rst_hit(rst_hit), .tx_req(tx_req), .sent_mask(sent_mask)
  );

  always_comb begin
    tx_index  = index_q;
    tx_wires  = state_q;
    reg_rdata = '0;
    if (reg_addr == SLOT_ADDR_W'(SLOT_INDEX)) begin
      reg_rdata[IDX_W-1:0] = index_q;
    end else if (reg_addr == SLOT_ADDR_W'(SLOT_RSTCFG)) begin
      reg_rdata[SRC_W-1:0]            = src_q;
      reg_rdata[MAP_LSB +: NUM_WIRES] = map_q;
    end else if (reg_addr == SLOT_ADDR_W'(SLOT_FLAGS)) begin
      reg_rdata[NUM_WIRES-1:0] = flag_q;
    end else begin
      for (int i = 0; i < NUM_WIRES; i++) begin
        if (reg_addr == SLOT_ADDR_W'(SLOT_WIRE0 + i)) reg_rdata[0] = state_q[i];
      end
    end
  end

  // R6: message wires only move on a write or a selected reset
  a_r6_wires_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !rst_hit) |=> $stable(tx_wires));
  // R9: the index survives reset pulses of any domain
  a_r9_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(tx_index));
endmodule

// File: tb/d2h_vwire_group_tb.sv
module d2h_vwire_group_tb;
  import vw_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [3:0] rst_evt;
  logic       tx_req;
  logic       tx_grant;
  logic [7:0] tx_index;
  logic [3:0] tx_wires;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_wires;

  d2h_vwire_group u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_evt(rst_evt),
    .tx_req(tx_req), .tx_grant(tx_grant), .tx_index(tx_index),
    .tx_wires(tx_wires)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [3:0] e);
    @(negedge clk);
    rst_evt = e;
    @(negedge clk);
    rst_evt = '0;
  endtask

  task automatic grant_once();
    @(negedge clk);
    tx_grant = 1'b1;
    @(negedge clk);
    tx_grant = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_evt = '0; tx_grant = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd_byte(3'(a), rd);
      check("R1 reset byte", {24'd0, rd}, 32'd0);
    end
    check("R1 tx_req", {31'd0, tx_req}, 32'd0);
    check("R1 tx_wires", {28'd0, tx_wires}, 32'd0);

    // R2 byte map
    wr_byte(3'(SLOT_INDEX), 8'h5A);
    rd_byte(3'(SLOT_INDEX), rd);
    check("R2 index rw", {24'd0, rd}, 32'h5A);
    check("R6 tx_index", {24'd0, tx_index}, 32'h5A);
    wr_byte(3'(SLOT_RSTCFG), 8'hFF);
    rd_byte(3'(SLOT_RSTCFG), rd);
    check("R2 cfg bits 3:2 read 0", {24'd0, rd}, 32'hF3);
    wr_byte(3'(SLOT_FLAGS), 8'hFF);
    rd_byte(3'(SLOT_FLAGS), rd);
    check("R2 flags write ignored", {24'd0, rd}, 32'h0);
    check("R2 flags write no req", {31'd0, tx_req}, 32'd0);
    wr_byte(3'd3, 8'hFF);
    rd_byte(3'd3, rd);
    check("R2 byte3 reads 0", {24'd0, rd}, 32'h0);
    wr_byte(3'(SLOT_WIRE0 + 2), 8'hFF);
    rd_byte(3'(SLOT_WIRE0 + 2), rd);
    check("R2 wire slot upper bits 0", {24'd0, rd}, 32'h01);
    check("R3 wire2 flag", {28'd0, tx_wires}, 32'h4);

    // R7 grant with no request earlier had nothing; now accept
    grant_once();
    check("R7 cleared", {31'd0, tx_req}, 32'd0);
    grant_once();
    check("R7 idle grant no effect wires", {28'd0, tx_wires}, 32'h4);
    check("R7 idle grant no effect req", {31'd0, tx_req}, 32'd0);
    exp_wires = 4'h4;

    // Sweep every old/new pattern pair, R3 R4 R5 R6 R7 R9
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        int s;
        int other;
        s = (o + n) % 4;
        other = (s + 1) % 4;
        wr_byte(3'(SLOT_RSTCFG), {4'(o), 2'b00, 2'(s)});
        pulse_evt(4'(1 << other));
        check("R9 other domain ignored", {28'd0, tx_wires}, {28'd0, exp_wires});
        pulse_evt(4'(1 << s));
        check("R9 selected domain loads", {28'd0, tx_wires}, 32'(o));
        check("R9 no req after reset", {31'd0, tx_req}, 32'd0);
        for (int w = 0; w < 4; w++) begin
          wr_byte(3'(SLOT_WIRE0 + w), {7'b1010101, 1'((n >> w) & 1)});
        end
        rd_byte(3'(SLOT_FLAGS), rd);
        check("R3/R4 flags", {24'd0, rd}, 32'(o ^ n));
        check("R5 req", {31'd0, tx_req}, {31'd0, (o != n)});
        check("R6 all wires", {28'd0, tx_wires}, 32'(n));
        grant_once();
        rd_byte(3'(SLOT_FLAGS), rd);
        check("R7 flags after accept", {24'd0, rd}, 32'd0);
        check("R7 req after accept", {31'd0, tx_req}, 32'd0);
        exp_wires = 4'(n);
      end
    end
    rd_byte(3'(SLOT_INDEX), rd);
    check("R9 index kept", {24'd0, rd}, 32'h5A);

    // R5 request holds without grant; exp_wires = 4'hF now
    wr_byte(3'(SLOT_WIRE0 + 0), 8'h00);
    repeat (5) @(negedge clk);
    check("R5 req holds", {31'd0, tx_req}, 32'd1);

    // R8 write to wire1 in the accept cycle
    @(negedge clk);
    tx_grant = 1'b1; reg_addr = 3'(SLOT_WIRE0 + 1); reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    tx_grant = 1'b0; reg_wr = 1'b0;
    rd_byte(3'(SLOT_FLAGS), rd);
    check("R8 new change pending", {24'd0, rd}, 32'h2);
    check("R8 req stays", {31'd0, tx_req}, 32'd1);
    // R8 rewrite of already-flagged wire1 during accept
    @(negedge clk);
    tx_grant = 1'b1; reg_addr = 3'(SLOT_WIRE0 + 1); reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk);
    tx_grant = 1'b0; reg_wr = 1'b0;
    rd_byte(3'(SLOT_FLAGS), rd);
    check("R8 flagged wire rechanged", {24'd0, rd}, 32'h2);
    check("R8 wires", {28'd0, tx_wires}, 32'hE);

    // R10 reset pulse beats simultaneous write
    wr_byte(3'(SLOT_RSTCFG), {4'h5, 2'b00, 2'(DOM_IO)});
    @(negedge clk);
    rst_evt = 4'b0100; reg_addr = 3'(SLOT_WIRE0 + 1); reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    rst_evt = '0; reg_wr = 1'b0;
    check("R10 wires", {28'd0, tx_wires}, 32'h5);
    rd_byte(3'(SLOT_FLAGS), rd);
    check("R10 flags", {24'd0, rd}, 32'h0);
    check("R10 req", {31'd0, tx_req}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule